// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page translations and answers lookups from a requester in the same cycle. Any slot may hold any virtual page. The requester presents a virtual address and a write flag. On a hit the block returns the physical address with the page offset passed through. On a miss it raises a miss flag in that same cycle, before the access completes, and changes no state. The requester then obtains the translation elsewhere, from a table walker or a software handler, writes it through the refill port, and retries.

Each slot carries a recently-used mark and a modified mark. A hit sets the recently-used mark, and a write hit also sets the modified mark. A refill fills a free slot first. If no slot is free, it replaces the lowest-numbered slot whose recently-used mark is clear. If every mark is set, all marks are cleared and slot 0 is replaced. This is a cheap approximation of least-recently-used replacement. When a valid translation is displaced, the refill cycle reports that page and its modified mark, so the requester can write the page back. A flush input empties the whole buffer in one cycle.

The victim choice is made by a priority selector with three named outcomes: VR_FREE (an empty slot), VR_COLD (a valid slot with a clear mark) and VR_SWEEP (all marks set: clear them all and take slot 0). In each cycle exactly one action is taken, in this priority: flush, then refill, then a lookup hit update.

Top module: `page_xlat_cache`

## Requirements
- R1: A lookup of a virtual page held in any slot raises `lk_hit` in the same cycle. `lk_paddr` is then the stored physical page number concatenated with the low `PAGE_W` bits of `lk_vaddr`. When there is no hit, `lk_paddr` is 0.
- R2: A served lookup of an absent page raises `lk_miss` in the same cycle and changes no stored state. A retry after the page has been refilled hits.
- R3: A hit sets that slot's recently-used mark. A slot marked this way is passed over by the next victim choice while a slot with a clear mark exists.
- R4: A write hit (`lk_write`=1) sets the slot's modified mark. When that slot is later displaced, `evict_dirty` is 1 in the refill cycle.
- R5: While any slot is empty, a refill of a new page goes into the lowest-numbered empty slot, and `evict_valid` stays 0.
- R6: With all slots valid and at least one recently-used mark clear, a refill replaces the lowest-numbered slot with a clear mark. In that cycle `evict_valid`=1, and `evict_vpn`/`evict_dirty` give the displaced page and its modified mark.
- R7: With all slots valid and all marks set, a refill clears every mark and replaces slot 0, reporting slot 0's page on the eviction outputs.
- R8: `flush` empties every slot in one cycle. A refill in the same cycle is dropped and reports no eviction. A lookup in the flush cycle is not served.
- R9: A lookup in the same cycle as a refill is not served: `lk_hit`=0 and `lk_miss`=0. A lookup in the following cycle sees the new entry.
- R10: A refill of a page already held updates that slot's physical page in place, reports no eviction and leaves every other slot unchanged.
- R11: With `lk_valid`=0, `lk_hit`, `lk_miss` and `lk_paddr` are all 0. After reset every slot is empty.
- R12: Capacity `ENTRIES` is a parameter (16 to 512, default 16). No virtual page is ever held in two slots at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Translation found (same cycle) |
| lk_miss | output | 1 | Translation absent (same cycle) |
| lk_paddr | output | PA_W | Translated physical address |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | VA_W-PAGE_W | Virtual page number being refilled |
| fill_ppn | input | PA_W-PAGE_W | Physical page number for it |
| flush | input | 1 | Empty the whole buffer |
| evict_valid | output | 1 | A valid translation is displaced by this refill |
| evict_vpn | output | VA_W-PAGE_W | Displaced virtual page |
| evict_dirty | output | 1 | Displaced page had been written |

## Verification
Hit, miss, physical address and the eviction report are all combinational results. Each is due in the very cycle its lookup or refill is driven. Mark updates, new entries and flushes take effect at the clock edge that ends that cycle, so they are checked through the result of the next lookup or refill. The driver applies inputs on the falling edge and queues the expected result for that cycle. The monitor compares 2 ns later, half a nanosecond before the closing rising edge, so every comparison sees the settled combinational outputs of exactly one cycle.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    // Outcome of the replacement choice for a refill
    typedef enum logic [1:0] {
        VR_FREE  = 2'd0,   // an empty slot exists
        VR_COLD  = 2'd1,   // a valid slot with a clear recently-used mark
        VR_SWEEP = 2'd2    // all marks set: clear all, take slot 0
    } victim_kind_e;

endpackage

// File: rtl/pxc_match.sv
module pxc_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);

    // One comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pxc_victim.sv
module pxc_victim
    import pxc_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] used,
    output logic [IDX_W-1:0]   idx,
    output victim_kind_e       kind
);

    logic [ENTRIES-1:0] free_v;
    logic [ENTRIES-1:0] cold_v;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   cold_idx;

    assign free_v = ~valid;
    assign cold_v = valid & ~used;

    // Lowest-index picks for each candidate class
    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_v[i]) free_idx = IDX_W'(i);
            if (cold_v[i]) cold_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (|free_v)      kind = VR_FREE;
        else if (|cold_v) kind = VR_COLD;
        else              kind = VR_SWEEP;
    end

    always_comb begin
        unique case (kind)
            VR_FREE:  idx = free_idx;
            VR_COLD:  idx = cold_idx;
            VR_SWEEP: idx = '0;
            default:  idx = '0;
        endcase
    end

endmodule

// File: rtl/page_xlat_cache.sv
module page_xlat_cache
    import pxc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PAGE_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_vaddr,
    input  logic                   lk_write,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic [PA_W-1:0]        lk_paddr,
    input  logic                   fill_valid,
    input  logic [VA_W-PAGE_W-1:0] fill_vpn,
    input  logic [PA_W-PAGE_W-1:0] fill_ppn,
    input  logic                   flush,
    output logic                   evict_valid,
    output logic [VA_W-PAGE_W-1:0] evict_vpn,
    output logic                   evict_dirty
);

    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PPN_W = PA_W - PAGE_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Slot state
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0]            used_q;
    logic [ENTRIES-1:0]            dirty_q;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

    // Lookup side
    logic [ENTRIES-1:0] lk_match;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic               serve;

    // Refill side
    logic [ENTRIES-1:0] fill_match;
    logic               fill_any;
    logic [IDX_W-1:0]   fill_idx;
    logic [IDX_W-1:0]   vic_idx;
    victim_kind_e       vic_kind;
    logic               do_fill;
    logic               fill_new;

    pxc_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_lk_match (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (lk_vaddr[VA_W-1:PAGE_W]),
        .match (lk_match),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    pxc_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_fill_match (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (fill_vpn),
        .match (fill_match),
        .any   (fill_any),
        .idx   (fill_idx)
    );

    pxc_victim #(.ENTRIES(ENTRIES)) i_victim (
        .valid (valid_q),
        .used  (used_q),
        .idx   (vic_idx),
        .kind  (vic_kind)
    );

    // Action selection: flush > refill > lookup
    assign do_fill  = fill_valid && !flush;
    assign fill_new = do_fill && !fill_any;
    assign serve    = lk_valid && !fill_valid && !flush;

    // Lookup outputs
    always_comb begin
        lk_hit   = serve && lk_any;
        lk_miss  = serve && !lk_any;
        lk_paddr = '0;
        if (serve && lk_any) begin
            lk_paddr = {ppn_q[lk_idx], lk_vaddr[PAGE_W-1:0]};
        end
    end

    // Eviction report
    always_comb begin
        evict_valid = 1'b0;
        evict_vpn   = '0;
        evict_dirty = 1'b0;
        if (fill_new && valid_q[vic_idx]) begin
            evict_valid = 1'b1;
            evict_vpn   = tag_q[vic_idx];
            evict_dirty = dirty_q[vic_idx];
        end
    end

    // Status bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            used_q  <= '0;
            dirty_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
            used_q  <= '0;
            dirty_q <= '0;
        end else if (fill_new) begin
            unique case (vic_kind)
                VR_SWEEP: used_q <= '0;
                VR_FREE, VR_COLD: ;
                default: ;
            endcase
            valid_q[vic_idx] <= 1'b1;
            used_q[vic_idx]  <= 1'b0;
            dirty_q[vic_idx] <= 1'b0;
        end else if (lk_hit) begin
            used_q[lk_idx] <= 1'b1;
            if (lk_write) dirty_q[lk_idx] <= 1'b1;
        end
    end

    // Translation payload (no reset needed; qualified by valid_q)
    always_ff @(posedge clk) begin
        if (do_fill) begin
            if (fill_any) begin
                ppn_q[fill_idx] <= fill_ppn;
            end else begin
                tag_q[vic_idx] <= fill_vpn;
                ppn_q[vic_idx] <= fill_ppn;
            end
        end
    end

    // ---------------- assertions ----------------
    a_r12_unique_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    a_r12_unique_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_match));

    a_r2_miss_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |=> $stable(valid_q) && $stable(used_q) && $stable(dirty_q));

    a_r3_hit_marks_used: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> used_q[$past(lk_idx)]);

    a_r4_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write) |=> dirty_q[$past(lk_idx)]);

    a_r5_free_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_new && !(&valid_q)) |-> !evict_valid);

    a_r7_sweep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_new && (&valid_q) && (&used_q)) |=> (used_q == '0));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    a_r9_fill_blocks_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !lk_hit && !lk_miss);

    a_r10_inplace_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (do_fill && fill_any) |=> $stable(valid_q));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit && !lk_miss && (lk_paddr == '0));

endmodule

// File: tb/test_page_xlat_cache.sv
`timescale 1ns/1ps
module test_page_xlat_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_miss;
    logic [31:0] lk_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        flush = 1'b0;
    logic        evict_valid;
    logic [19:0] evict_vpn;
    logic        evict_dirty;

    always #2.5 clk = ~clk;

    page_xlat_cache i_page_xlat_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .flush(flush),
        .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_dirty(evict_dirty)
    );

    typedef struct packed {
        logic        hit;
        logic        miss;
        logic [31:0] pa;
        logic        ev;
        logic [19:0] evvpn;
        logic        evd;
    } exp_t;

    exp_t  sb_q[$];
    string rq_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Driver: one cycle of stimulus plus its expected result
    task automatic step(input bit lv, input logic [31:0] va, input bit wr,
                        input bit fv, input logic [19:0] fvpn, input logic [19:0] fppn,
                        input bit fl, input exp_t e, input string req);
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; lk_write = wr;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; flush = fl;
        sb_q.push_back(e);
        rq_q.push_back(req);
    endtask

    task automatic look(input logic [31:0] va, input bit wr, input bit eh,
                        input logic [31:0] epa, input string req);
        exp_t e;
        e = '{hit: eh, miss: !eh, pa: eh ? epa : 32'h0, ev: 1'b0, evvpn: 20'h0, evd: 1'b0};
        step(1'b1, va, wr, 1'b0, 20'h0, 20'h0, 1'b0, e, req);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input bit ee,
                        input logic [19:0] eev, input bit eed, input string req);
        exp_t e;
        e = '{hit: 1'b0, miss: 1'b0, pa: 32'h0, ev: ee, evvpn: ee ? eev : 20'h0, evd: ee & eed};
        step(1'b0, 32'h0, 1'b0, 1'b1, vpn, ppn, 1'b0, e, req);
    endtask

    task automatic idle(input logic [31:0] va, input string req);
        exp_t e;
        e = '0;
        step(1'b0, va, 1'b0, 1'b0, 20'h0, 20'h0, 1'b0, e, req);
    endtask

    // Monitor: compare 0.5 ns before the closing rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string r;
                e = sb_q.pop_front();
                r = rq_q.pop_front();
                a = '{hit: lk_hit, miss: lk_miss, pa: lk_paddr, ev: evict_valid,
                      evvpn: evict_vpn, evd: evict_dirty};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b miss=%0b pa=%h ev=%0b evvpn=%h evd=%0b expected hit=%0b miss=%0b pa=%h ev=%0b evvpn=%h evd=%0b",
                             r, a.hit, a.miss, a.pa, a.ev, a.evvpn, a.evd,
                             e.hit, e.miss, e.pa, e.ev, e.evvpn, e.evd);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state and idle lookup port
        idle(32'h0000_5123, "R11");
        look(32'h0000_5123, 1'b0, 1'b0, 32'h0, "R2");              // empty after reset
        // R5 / R2: refill then retry
        fill(20'h00005, 20'hABCDE, 1'b0, 20'h0, 1'b0, "R5");
        look(32'h0000_5123, 1'b0, 1'b1, 32'hABCD_E123, "R1");
        // Fill slots 1..15 with vpn 0x10..0x1E -> ppn vpn+0x100
        for (int v = 16; v <= 30; v++) begin
            fill(20'(v), 20'(v + 256), 1'b0, 20'h0, 1'b0, "R5");
        end
        look(32'h0001_EFFF, 1'b0, 1'b1, 32'h0011_EFFF, "R1");
        look(32'h0001_1040, 1'b1, 1'b1, 32'h0011_1040, "R4");       // write hit slot 2
        look(32'h0001_0008, 1'b0, 1'b1, 32'h0011_0008, "R3");       // slot 1 used
        idle(32'h0001_0008, "R11");                                  // present page, no request
        // R6: marks set on slots 0,1,2,15 -> slot 3 (vpn 0x12) displaced
        fill(20'h00040, 20'h00140, 1'b1, 20'h00012, 1'b0, "R6");
        look(32'h0001_2000, 1'b0, 1'b0, 32'h0, "R6");
        look(32'h0004_0000, 1'b0, 1'b1, 32'h0014_0000, "R6");
        // Mark slots 4..14 (vpn 0x13..0x1D)
        for (int v = 19; v <= 29; v++) begin
            look({12'h0, 8'(v), 12'h0}, 1'b0, 1'b1, {12'h0, 8'(v + 256 - 256), 12'h0} | 32'h0010_0000, "R3");
        end
        // R7: all marked -> sweep, slot 0 (vpn 5) displaced
        fill(20'h00050, 20'h00150, 1'b1, 20'h00005, 1'b0, "R7");
        look(32'h0005_0000, 1'b0, 1'b1, 32'h0015_0000, "R7");
        // Marks were cleared: slot 1 (vpn 0x10) now cold
        fill(20'h00051, 20'h00151, 1'b1, 20'h00010, 1'b0, "R7");
        look(32'h0005_1000, 1'b0, 1'b1, 32'h0015_1000, "R3");
        // R4: slot 2 (vpn 0x11) was written -> dirty eviction
        fill(20'h00052, 20'h00152, 1'b1, 20'h00011, 1'b1, "R4");
        // R10: in-place update
        fill(20'h00052, 20'h00999, 1'b0, 20'h0, 1'b0, "R10");
        look(32'h0005_2000, 1'b0, 1'b1, 32'h0099_9000, "R10");
        look(32'h0001_3000, 1'b0, 1'b1, 32'h0011_3000, "R10");
        // R9: lookup with concurrent refill not served; slot 3 (vpn 0x40) displaced
        begin
            exp_t e;
            e = '{hit: 1'b0, miss: 1'b0, pa: 32'h0, ev: 1'b1, evvpn: 20'h00040, evd: 1'b0};
            step(1'b1, 32'h0006_0ABC, 1'b0, 1'b1, 20'h00060, 20'h00160, 1'b0, e, "R9");
        end
        look(32'h0006_0ABC, 1'b0, 1'b1, 32'h0016_0ABC, "R9");
        // R8: flush with concurrent refill and lookup
        begin
            exp_t e;
            e = '0;
            step(1'b1, 32'h0006_0000, 1'b0, 1'b1, 20'h00070, 20'h00170, 1'b1, e, "R8");
        end
        look(32'h0006_0000, 1'b0, 1'b0, 32'h0, "R8");
        look(32'h0007_0000, 1'b0, 1'b0, 32'h0, "R8");
        fill(20'h00070, 20'h00170, 1'b0, 20'h0, 1'b0, "R5");
        look(32'h0007_0444, 1'b1, 1'b1, 32'h0017_0444, "R12");
        idle(32'h0007_0444, "R11");

        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule